// File: doc/BRIEF.md
# Converter Sample Pacer

This block paces a byte-wide parallel analogue-to-digital converter from a 1 MHz reference clock. A 4-bit rate code chooses a divisor from a fixed menu of twelve rates, from 500 kHz down to 1 Hz. The divider emits one sample tick per period. On each tick a small state machine drives the converter's active-low chip-select and read strobes for one reference cycle, which is longer than the 660 ns conversion. It then latches the byte on the closing edge and presents it as a 9-bit word on a buffer write port with a one-cycle write strobe.

An active-low inhibit line acts as a synchronous reset. While it is low, nothing is sampled and nothing is written. If the buffer reports full when a sample closes, the sample is discarded and a sticky overrun flag is raised. A new rate code is loaded only at a sample boundary, and that boundary also restarts the divider count.

The state machine has three states:
- `ST_IDLE` waits for a tick (IDLE→CONVERT on tick).
- `ST_CONVERT` holds both strobes low for one cycle and always moves on (CONVERT→DELIVER).
- `ST_DELIVER` pulses the write strobe if the sample was kept. It goes back to CONVERT if a tick arrives in that cycle, otherwise to IDLE (DELIVER→CONVERT, DELIVER→IDLE).

Top module: `adc_pacer`

## Requirements
- R1: While `inhibit_n` is sampled low at a rising edge, the next cycle shows `adc_cs_n`=1, `adc_rd_n`=1, `fifo_wr`=0 and `overrun`=0. No sample started before or during inhibit is ever written.
- R2: Rate codes 0..11 select the divisors 2, 4, 5, 10, 20, 40, 50, 100, 1000, 10000, 100000 and 1000000. Successive writes are exactly that many cycles apart. The first write after `inhibit_n` rises is high in the cycle that follows the (divisor+1)-th rising edge.
- R3: Rate codes 12..15 behave as code 11 (divisor 1000000).
- R4: For each sample, `adc_cs_n` and `adc_rd_n` are low together for exactly one cycle, and that cycle is the one just before the write cycle.
- R5: `fifo_wdata[7:0]` equals the value on `adc_data` at the rising edge that ends the strobe cycle, and `fifo_wdata[8]` is 0.
- R6: `fifo_wr` is high for exactly one cycle per captured sample.
- R7: If `fifo_full` is high at the edge that ends the strobe cycle, no write happens for that sample and `overrun` becomes 1.
- R8: `overrun` stays at 1 until `inhibit_n` is low, even after `fifo_full` drops.
- R9: A change of `rate_sel` takes effect only at the next sample tick. The period in progress keeps the old divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 1 MHz reference clock |
| inhibit_n | input | 1 | Active-low synchronous reset and sampling inhibit |
| rate_sel | input | 4 | Sample rate code |
| adc_data | input | 8 | Converter output byte |
| fifo_full | input | 1 | Buffer full flag |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_rd_n | output | 1 | Converter read strobe, active low |
| fifo_wdata | output | 9 | Buffer write word, bit 8 zero |
| fifo_wr | output | 1 | One-cycle buffer write strobe |
| overrun | output | 1 | Sticky dropped-sample flag |

## Verification
The bench drives a data byte only while the strobes are low and drives a scrambled byte at all other times, so a capture taken on the wrong edge shows up as a data mismatch. It runs the fastest rate, where each DELIVER cycle jumps straight back to CONVERT. A design that let two samples overlap would produce double writes or broken spacing there.

It changes the rate code in the middle of a period and expects one more interval at the old divisor. A design that reloaded immediately would shorten that interval. It also holds the buffer full over several samples, expecting writes to stop and the overrun flag to survive the full flag's release and clear only under inhibit. Finally, an out-of-menu code is held for thirty thousand cycles and must produce no strobe at all, which exposes any fallback to a fast divisor.

// File: rtl/adc_pacer_pkg.sv
package adc_pacer_pkg;

    localparam int SEL_W  = 4;
    localparam int DIV_W  = 20;
    localparam int DATA_W = 8;
    localparam int WORD_W = 9;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CONVERT,
        ST_DELIVER
    } pace_state_t;

    // Rate code to reference-clock divisor; undefined codes fall to the slowest rate.
    function automatic logic [DIV_W-1:0] rate_divisor(input logic [SEL_W-1:0] code);
        logic [DIV_W-1:0] d;
        case (code)
            4'd0:    d = DIV_W'(2);
            4'd1:    d = DIV_W'(4);
            4'd2:    d = DIV_W'(5);
            4'd3:    d = DIV_W'(10);
            4'd4:    d = DIV_W'(20);
            4'd5:    d = DIV_W'(40);
            4'd6:    d = DIV_W'(50);
            4'd7:    d = DIV_W'(100);
            4'd8:    d = DIV_W'(1000);
            4'd9:    d = DIV_W'(10000);
            4'd10:   d = DIV_W'(100000);
            default: d = DIV_W'(1000000);
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pacer_divider.sv
module pacer_divider
    import adc_pacer_pkg::*;
#(
    parameter int SW = SEL_W,
    parameter int CW = DIV_W
) (
    input  logic          clk,
    input  logic          inhibit_n,
    input  logic [SW-1:0] rate_sel,
    output logic          tick
);

    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] div_q;
    logic          wrap;

    assign wrap = (cnt_q == div_q - ONE);
    assign tick = inhibit_n && wrap;

    // Divisor is reloaded only at the wrap, so a new code waits for the boundary.
    always_ff @(posedge clk) begin
        if (!inhibit_n) begin
            cnt_q <= '0;
            div_q <= CW'(rate_divisor(rate_sel));
        end else if (wrap) begin
            cnt_q <= '0;
            div_q <= CW'(rate_divisor(rate_sel));
        end else begin
            cnt_q <= cnt_q + ONE;
        end
    end

    // R2: divisor of at least two keeps ticks apart
    a_r2_tick_gap: assert property (@(posedge clk) disable iff (!inhibit_n)
        tick |=> !tick);

    // R9: divisor only changes at a tick
    a_r9_div_hold: assert property (@(posedge clk) disable iff (!inhibit_n)
        !tick |=> $stable(div_q));

endmodule

// File: rtl/pacer_fsm.sv
module pacer_fsm
    import adc_pacer_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int WW = WORD_W
) (
    input  logic          clk,
    input  logic          inhibit_n,
    input  logic          tick,
    input  logic [DW-1:0] adc_data,
    input  logic          fifo_full,
    output logic          adc_cs_n,
    output logic          adc_rd_n,
    output logic [WW-1:0] fifo_wdata,
    output logic          fifo_wr,
    output logic          overrun
);

    localparam int PAD = WW - DW;

    pace_state_t   state_q, state_d;
    logic [DW-1:0] data_q;
    logic          keep_q;
    logic          overrun_q;

    // State register
    always_ff @(posedge clk) begin
        if (!inhibit_n) state_q <= ST_IDLE;
        else            state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = tick ? ST_CONVERT : ST_IDLE;
            ST_CONVERT: state_d = ST_DELIVER;
            ST_DELIVER: state_d = tick ? ST_CONVERT : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Capture at the edge closing the strobe cycle
    always_ff @(posedge clk) begin
        if (!inhibit_n) begin
            data_q    <= '0;
            keep_q    <= 1'b0;
            overrun_q <= 1'b0;
        end else if (state_q == ST_CONVERT) begin
            data_q <= adc_data;
            keep_q <= !fifo_full;
            if (fifo_full) overrun_q <= 1'b1;
        end
    end

    // Outputs
    always_comb begin
        adc_cs_n   = (state_q != ST_CONVERT);
        adc_rd_n   = (state_q != ST_CONVERT);
        fifo_wr    = (state_q == ST_DELIVER) && keep_q;
        fifo_wdata = {{PAD{1'b0}}, data_q};
        overrun    = overrun_q;
    end

    // R6: write strobe lasts one cycle
    a_r6_single_write: assert property (@(posedge clk) disable iff (!inhibit_n)
        fifo_wr |=> !fifo_wr);

    // R4: every write is preceded by the strobe cycle
    a_r4_strobe_before_write: assert property (@(posedge clk) disable iff (!inhibit_n)
        fifo_wr |-> $past(!adc_cs_n && !adc_rd_n));

    // R7: a full buffer at capture suppresses the write
    a_r7_full_drop: assert property (@(posedge clk) disable iff (!inhibit_n)
        (!adc_cs_n && fifo_full) |=> (!fifo_wr && overrun));

    // R8: overrun is sticky
    a_r8_overrun_sticky: assert property (@(posedge clk) disable iff (!inhibit_n)
        overrun |=> overrun);

endmodule

// File: rtl/adc_pacer.sv
module adc_pacer
    import adc_pacer_pkg::*;
#(
    parameter int SW = SEL_W,
    parameter int CW = DIV_W,
    parameter int DW = DATA_W,
    parameter int WW = WORD_W
) (
    input  logic          clk,
    input  logic          inhibit_n,
    input  logic [SW-1:0] rate_sel,
    input  logic [DW-1:0] adc_data,
    input  logic          fifo_full,
    output logic          adc_cs_n,
    output logic          adc_rd_n,
    output logic [WW-1:0] fifo_wdata,
    output logic          fifo_wr,
    output logic          overrun
);

    logic tick;

    pacer_divider #(.SW(SW), .CW(CW)) u_div (
        .clk       (clk),
        .inhibit_n (inhibit_n),
        .rate_sel  (rate_sel),
        .tick      (tick)
    );

    pacer_fsm #(.DW(DW), .WW(WW)) u_fsm (
        .clk        (clk),
        .inhibit_n  (inhibit_n),
        .tick       (tick),
        .adc_data   (adc_data),
        .fifo_full  (fifo_full),
        .adc_cs_n   (adc_cs_n),
        .adc_rd_n   (adc_rd_n),
        .fifo_wdata (fifo_wdata),
        .fifo_wr    (fifo_wr),
        .overrun    (overrun)
    );

    // R4: a strobe never starts in the cycle right after another strobe
    a_r4_one_cycle_strobe: assert property (@(posedge clk) disable iff (!inhibit_n)
        !adc_cs_n |=> adc_cs_n);

endmodule

// File: tb/tb_adc_pacer.sv
module tb_adc_pacer;

    logic       clk = 1'b0;
    logic       inhibit_n;
    logic [3:0] rate_sel;
    logic [7:0] adc_data;
    logic       fifo_full;
    logic       adc_cs_n, adc_rd_n, fifo_wr, overrun;
    logic [8:0] fifo_wdata;

    always #4 clk = ~clk;

    adc_pacer dut (
        .clk(clk), .inhibit_n(inhibit_n), .rate_sel(rate_sel), .adc_data(adc_data),
        .fifo_full(fifo_full), .adc_cs_n(adc_cs_n), .adc_rd_n(adc_rd_n),
        .fifo_wdata(fifo_wdata), .fifo_wr(fifo_wr), .overrun(overrun)
    );

    int checks = 0, bad = 0;
    int cyc = 0, wr_total = 0, st_total = 0;
    int v_run = 0, v_pair = 0, v_dbl = 0, v_inh = 0, strobe_run = 0;
    int wr_t[$];
    logic [7:0] exp_q[$];
    logic [7:0] smp = 8'h17;
    logic inh_at_edge = 1'b0, prev_cs_low = 1'b0, prev_wr = 1'b0;
    bit done = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= inhibit_n ? cyc + 1 : 0;
        inh_at_edge <= inhibit_n;
    end

    // Monitor and converter model (scoreboard)
    always @(negedge clk) begin
        if (!adc_cs_n) strobe_run++;
        else begin
            if (strobe_run > 1) v_run++;
            strobe_run = 0;
        end
        if (adc_cs_n != adc_rd_n) v_pair++;
        if (!inh_at_edge && (!adc_cs_n || !adc_rd_n || fifo_wr || overrun)) v_inh++;
        if (!inh_at_edge) exp_q.delete();
        if (fifo_wr && prev_wr) v_dbl++;
        if (fifo_wr) begin
            check(prev_cs_low, "R4 strobe precedes write", prev_cs_low, 1);
            if (exp_q.size() == 0) check(0, "R5 unexpected write", 0, 1);
            else begin
                logic [7:0] e;
                e = exp_q.pop_front();
                check(fifo_wdata == {1'b0, e}, "R5 captured word", fifo_wdata, {1'b0, e});
            end
            wr_t.push_back(cyc);
            wr_total++;
        end
        if (!adc_cs_n && !adc_rd_n) begin
            st_total++;
            smp = smp * 8'd37 + 8'd11;
            adc_data = smp;
            if (!fifo_full && inhibit_n) exp_q.push_back(smp);
        end else begin
            adc_data = smp ^ 8'hA5;
        end
        prev_cs_low = !adc_cs_n;
        prev_wr = fifo_wr;
    end

    task automatic run_rate(input int code, input int div, input int n);
        @(posedge clk); #2;
        inhibit_n = 1'b0;
        rate_sel = 4'(code);
        repeat (3) @(posedge clk);
        #2;
        wr_t.delete();
        inhibit_n = 1'b1;
        for (int i = 0; i < n * div + div + 20 && wr_t.size() < n; i++) begin
            @(negedge clk); #1;
        end
        check(wr_t.size() == n, $sformatf("R2 write count code %0d", code), wr_t.size(), n);
        if (wr_t.size() > 0)
            check(wr_t[0] == div + 1, $sformatf("R2 first write code %0d", code), wr_t[0], div + 1);
        for (int k = 1; k < wr_t.size(); k++)
            check(wr_t[k] - wr_t[k-1] == div, $sformatf("R2 spacing code %0d", code),
                  wr_t[k] - wr_t[k-1], div);
    endtask

    initial begin
        int base;
        inhibit_n = 1'b0;
        rate_sel  = 4'd3;
        fifo_full = 1'b0;
        repeat (5) @(negedge clk);
        #1;
        check(adc_cs_n == 1'b1, "R1 reset cs_n", adc_cs_n, 1);
        check(adc_rd_n == 1'b1, "R1 reset rd_n", adc_rd_n, 1);
        check(fifo_wr == 1'b0, "R1 reset wr", fifo_wr, 0);
        check(overrun == 1'b0, "R1 reset overrun", overrun, 0);

        run_rate(0, 2, 6);
        run_rate(1, 4, 4);
        run_rate(2, 5, 4);
        run_rate(3, 10, 3);
        run_rate(5, 40, 3);
        run_rate(6, 50, 3);
        run_rate(8, 1000, 3);
        run_rate(9, 10000, 2);

        // R9: change mid-period
        run_rate(3, 10, 2);
        @(posedge clk); #2;
        rate_sel = 4'd0;
        for (int i = 0; i < 100 && wr_t.size() < 5; i++) begin
            @(negedge clk); #1;
        end
        check(wr_t.size() >= 5, "R9 writes after change", wr_t.size(), 5);
        if (wr_t.size() >= 5) begin
            check(wr_t[2] - wr_t[1] == 10, "R9 old period kept", wr_t[2] - wr_t[1], 10);
            check(wr_t[3] - wr_t[2] == 2, "R9 new period", wr_t[3] - wr_t[2], 2);
            check(wr_t[4] - wr_t[3] == 2, "R9 new period again", wr_t[4] - wr_t[3], 2);
        end

        // R7 / R8
        run_rate(1, 4, 2);
        @(posedge clk); #2;
        fifo_full = 1'b1;
        base = wr_total;
        repeat (20) @(negedge clk);
        #1;
        check(wr_total == base, "R7 no write while full", wr_total - base, 0);
        check(overrun == 1'b1, "R7 overrun set", overrun, 1);
        @(posedge clk); #2;
        fifo_full = 1'b0;
        base = wr_total;
        repeat (20) @(negedge clk);
        #1;
        check(overrun == 1'b1, "R8 overrun sticky", overrun, 1);
        check(wr_total > base, "R8 writes resume", wr_total - base, 5);

        // R1 mid-run inhibit also clears overrun (R8)
        @(posedge clk); #2;
        inhibit_n = 1'b0;
        base = wr_total;
        repeat (2) @(posedge clk);
        @(negedge clk); #1;
        check(overrun == 1'b0, "R8 overrun cleared by inhibit", overrun, 0);
        repeat (50) @(negedge clk);
        #1;
        check(wr_total == base, "R1 no writes while inhibited", wr_total - base, 0);

        // R3: out-of-menu code runs at the slowest rate
        rate_sel = 4'd13;
        @(posedge clk); #2;
        inhibit_n = 1'b1;
        base = st_total;
        repeat (30000) @(negedge clk);
        #1;
        check(st_total == base, "R3 no sample with code 13", st_total - base, 0);

        check(v_run == 0, "R4 strobe width", v_run, 0);
        check(v_pair == 0, "R4 strobes paired", v_pair, 0);
        check(v_dbl == 0, "R6 single-cycle write", v_dbl, 0);
        check(v_inh == 0, "R1 quiet under inhibit", v_inh, 0);

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1;
            checks++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

endmodule